// File: doc/BRIEF.md
# Periodic frame list index generator

This block holds the host controller's micro-frame counter and derives from it the system memory address of the periodic frame list entry that the schedule engine should fetch next. A 14-bit frame index counts one step per end-of-micro-frame strobe while the controller runs. The list index is a slice of that counter whose upper end depends on the configured list length. The lowest three counter bits are left out of the slice, so one list entry stays current for eight micro-frames in a row. The slice is joined to a 4 KB-aligned base address to form a word-aligned entry pointer. A one-cycle pulse marks the point where the list index returns to entry zero.

Software sees two 32-bit registers through a simple write port with byte enables and a combinational read mux. Select 0 is the frame index and select 1 is the list base. The block also keeps the USB interrupt status flag and its enable. A small state machine (`IRQ_IDLE`, `IRQ_ARMED`, `IRQ_FIRE`) holds back the interrupt output until the next threshold boundary. The threshold is a programmable number of micro-frames. The machine moves `IRQ_IDLE`→`IRQ_ARMED` when status and enable are both set. It moves `IRQ_ARMED`→`IRQ_FIRE` on a counter advance that lands on a threshold boundary. It returns from `IRQ_ARMED` or `IRQ_FIRE` to `IRQ_IDLE` when status or enable drops.

Top module: `pfl_index_gen`

## Requirements
- R1: After reset the frame index, the list base, `irq_status`, `irq` and `list_wrap` are all 0. A read with `bus_sel`=0 returns the frame index in bits 13:0 and zeros in bits 31:14.
- R2: The frame index adds one, modulo 2^14, at each clock edge where `uframe_end` and `run_en` are both 1. When `run_en` is 0 it holds its value, even with `uframe_end` high.
- R3: A write with `bus_sel`=0 and `bus_be`=4'b1111 loads `bus_wdata[13:0]` into the frame index only when `run_en` is 0. While `run_en` is 1 the write has no effect.
- R4: A write with any `bus_be` bit at 0 changes neither register.
- R5: A full write with `bus_sel`=1 stores `bus_wdata[31:12]` as the list base. Reads with `bus_sel`=1 return the base in bits 31:12 and zeros in bits 11:0.
- R6: `entry_addr` = {base[31:12], idx[9:0], 2'b00}, where idx is frame index bits [N:3] zero-extended to 10 bits. `list_size` 00 selects N=12, 01 selects N=11, 10 selects N=10, and 11 (reserved) selects N=12.
- R7: `list_wrap` is high for exactly the one cycle that follows an advance in which frame index bit N went from 1 to 0, and is low otherwise.
- R8: `evt_set` sets `irq_status` and `sts_clr` clears it, both at the next edge. When both are high, the set wins.
- R9: `irq` rises only in the cycle after an advance whose new frame index has its low k bits all zero. `irq_thr` 00/01/10/11 gives k=0/1/2/3, which is a threshold of 1/2/4/8 micro-frames. The advance counts only if status and enable had both been 1 for at least one earlier cycle.
- R10: `irq` falls in the same cycle that `irq_status` reads 0 or `irq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Controller running; enables counting and blocks index writes |
| uframe_end | input | 1 | End-of-micro-frame strobe |
| list_size | input | 2 | Frame list length code |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 frame index, 1 list base |
| bus_be | input | 4 | Byte enables; only 4'b1111 writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| evt_set | input | 1 | Sets the interrupt status flag |
| sts_clr | input | 1 | Software acknowledge; clears the status flag |
| irq_en | input | 1 | Interrupt enable |
| irq_thr | input | 2 | Interrupt threshold code |
| entry_addr | output | 32 | Address of the current frame list entry |
| list_wrap | output | 1 | One-cycle pulse when the list index returns to zero |
| irq_status | output | 1 | Interrupt status flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or a wrong slice boundary appears on `entry_addr` in the very cycle after the faulty advance. A full-length sweep for every list-size code therefore catches it within eight micro-frames of the first divergence. A wrap detector keyed to the wrong bit shows up as a misplaced or missing `list_wrap` pulse within one list length. A state machine that fires early, or never leaves `IRQ_FIRE`, shows on `irq` at the first advance after arming or right after the acknowledge.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

    localparam int FIDX_W_DEF = 14;
    localparam int ADDR_W_DEF = 32;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_ARMED = 2'd1,
        IRQ_FIRE  = 2'd2
    } irq_state_e;

    typedef enum logic [1:0] {
        LEN_FULL    = 2'b00,
        LEN_HALF    = 2'b01,
        LEN_QUARTER = 2'b10,
        LEN_RSVD    = 2'b11
    } list_len_e;

    // How many bits the slice's top end sits below the widest setting.
    function automatic logic [1:0] len_shrink(input logic [1:0] code);
        logic [1:0] s;
        case (code)
            LEN_HALF:    s = 2'd1;
            LEN_QUARTER: s = 2'd2;
            default:     s = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pfl_regs.sv
module pfl_regs #(
    parameter int FIDX_W = 14,
    parameter int ADDR_W = 32,
    localparam int IDX_W    = FIDX_W - 4,
    localparam int BASE_LSB = IDX_W + 2,
    localparam int BASE_W   = ADDR_W - BASE_LSB,
    localparam int BE_W     = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [ADDR_W-1:0] bus_wdata,
    input  logic [FIDX_W-1:0] fidx,
    output logic              fidx_load,
    output logic [FIDX_W-1:0] fidx_load_val,
    output logic [BASE_W-1:0] base_q,
    output logic [ADDR_W-1:0] bus_rdata
);

    logic full_word;
    logic base_we;

    assign full_word     = &bus_be;
    assign fidx_load     = bus_wr && full_word && !bus_sel && !run_en;
    assign base_we       = bus_wr && full_word && bus_sel;
    assign fidx_load_val = bus_wdata[FIDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_we) begin
            base_q <= bus_wdata[ADDR_W-1:BASE_LSB];
        end
    end

    always_comb begin
        if (bus_sel) begin
            bus_rdata = {base_q, {BASE_LSB{1'b0}}};
        end else begin
            bus_rdata = {{(ADDR_W-FIDX_W){1'b0}}, fidx};
        end
    end

endmodule

// File: rtl/pfl_counter.sv
module pfl_counter
    import pfl_pkg::*;
#(
    parameter int FIDX_W = 14,
    localparam int IDX_W  = FIDX_W - 4,
    localparam int SPAN_W = FIDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              load,
    input  logic [FIDX_W-1:0] load_val,
    input  logic [1:0]        list_size,
    input  logic [1:0]        irq_thr,
    output logic [FIDX_W-1:0] fidx_q,
    output logic [IDX_W-1:0]  list_idx,
    output logic              list_wrap,
    output logic              thr_hit
);

    logic [1:0]        shrink;
    logic [SPAN_W-1:0] span_mask;
    logic [FIDX_W-1:0] fidx_next;
    logic              at_top;
    logic [2:0]        thr_mask;

    assign shrink    = len_shrink(list_size);
    assign span_mask = {SPAN_W{1'b1}} >> shrink;
    assign fidx_next = fidx_q + 1'b1;
    // Bit N falls from 1 to 0 exactly when bits N..0 are all ones.
    assign at_top    = (fidx_q[SPAN_W-1:0] & span_mask) == span_mask;
    assign list_idx  = fidx_q[SPAN_W-1:3] & ({IDX_W{1'b1}} >> shrink);

    always_comb begin
        case (irq_thr)
            2'd0:    thr_mask = 3'b000;
            2'd1:    thr_mask = 3'b001;
            2'd2:    thr_mask = 3'b011;
            default: thr_mask = 3'b111;
        endcase
    end

    assign thr_hit = adv && ((fidx_next[2:0] & thr_mask) == 3'b000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fidx_q <= '0;
        end else if (adv) begin
            fidx_q <= fidx_next;
        end else if (load) begin
            fidx_q <= load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            list_wrap <= 1'b0;
        end else begin
            list_wrap <= adv && at_top;
        end
    end

endmodule

// File: rtl/pfl_irq_fsm.sv
module pfl_irq_fsm
    import pfl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_set,
    input  logic sts_clr,
    input  logic irq_en,
    input  logic thr_hit,
    output logic irq_status,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       live;

    assign live = irq_status && irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_status <= 1'b0;
        end else if (evt_set) begin
            irq_status <= 1'b1;
        end else if (sts_clr) begin
            irq_status <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (live) state_d = IRQ_ARMED;
            end
            IRQ_ARMED: begin
                if (!live)        state_d = IRQ_IDLE;
                else if (thr_hit) state_d = IRQ_FIRE;
            end
            IRQ_FIRE: begin
                if (!live) state_d = IRQ_IDLE;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_FIRE) && live;
    end

endmodule

// File: rtl/pfl_index_gen.sv
module pfl_index_gen
    import pfl_pkg::*;
#(
    parameter int FIDX_W = FIDX_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    localparam int IDX_W    = FIDX_W - 4,
    localparam int BASE_LSB = IDX_W + 2,
    localparam int BASE_W   = ADDR_W - BASE_LSB,
    localparam int BE_W     = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              uframe_end,
    input  logic [1:0]        list_size,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [ADDR_W-1:0] bus_wdata,
    output logic [ADDR_W-1:0] bus_rdata,
    input  logic              evt_set,
    input  logic              sts_clr,
    input  logic              irq_en,
    input  logic [1:0]        irq_thr,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              list_wrap,
    output logic              irq_status,
    output logic              irq
);

    logic [FIDX_W-1:0] fidx_q;
    logic [BASE_W-1:0] base_q;
    logic              fidx_load;
    logic [FIDX_W-1:0] fidx_load_val;
    logic [IDX_W-1:0]  list_idx;
    logic              thr_hit;
    logic              adv;

    assign adv = uframe_end && run_en;

    pfl_regs #(.FIDX_W(FIDX_W), .ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .bus_wr        (bus_wr),
        .bus_sel       (bus_sel),
        .bus_be        (bus_be),
        .bus_wdata     (bus_wdata),
        .fidx          (fidx_q),
        .fidx_load     (fidx_load),
        .fidx_load_val (fidx_load_val),
        .base_q        (base_q),
        .bus_rdata     (bus_rdata)
    );

    pfl_counter #(.FIDX_W(FIDX_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .load      (fidx_load),
        .load_val  (fidx_load_val),
        .list_size (list_size),
        .irq_thr   (irq_thr),
        .fidx_q    (fidx_q),
        .list_idx  (list_idx),
        .list_wrap (list_wrap),
        .thr_hit   (thr_hit)
    );

    pfl_irq_fsm u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_set    (evt_set),
        .sts_clr    (sts_clr),
        .irq_en     (irq_en),
        .thr_hit    (thr_hit),
        .irq_status (irq_status),
        .irq        (irq)
    );

    assign entry_addr = {base_q, list_idx, 2'b00};

endmodule

// File: rtl/pfl_index_gen_chk.sv
module pfl_index_gen_chk #(
    parameter int FIDX_W = 14,
    parameter int ADDR_W = 32,
    localparam int BASE_LSB = FIDX_W - 2,
    localparam int BASE_W   = ADDR_W - BASE_LSB,
    localparam int BE_W     = ADDR_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              uframe_end,
    input logic              bus_wr,
    input logic              bus_sel,
    input logic [BE_W-1:0]   bus_be,
    input logic [ADDR_W-1:0] bus_rdata,
    input logic              evt_set,
    input logic [ADDR_W-1:0] entry_addr,
    input logic              list_wrap,
    input logic              irq_status,
    input logic              irq,
    input logic [FIDX_W-1:0] fidx,
    input logic [BASE_W-1:0] base
);

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> bus_rdata[ADDR_W-1:FIDX_W] == '0);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && uframe_end) |=> fidx == FIDX_W'($past(fidx) + 1'b1));

    assert_run_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !uframe_end) |=> $stable(fidx));

    assert_partial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !(&bus_be) && !(run_en && uframe_end)) |=> ($stable(fidx) && $stable(base)));

    assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        list_wrap |-> entry_addr[BASE_LSB-1:2] == '0);

    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set |=> irq_status);

    assert_irq_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(run_en && uframe_end));

    assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_status);

endmodule

bind pfl_index_gen pfl_index_gen_chk #(.FIDX_W(FIDX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .uframe_end (uframe_end),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_be     (bus_be),
    .bus_rdata  (bus_rdata),
    .evt_set    (evt_set),
    .entry_addr (entry_addr),
    .list_wrap  (list_wrap),
    .irq_status (irq_status),
    .irq        (irq),
    .fidx       (fidx_q),
    .base       (base_q)
);

// File: tb/tb_pfl_index_gen.sv
module tb_pfl_index_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        uframe_end = 1'b0;
    logic [1:0]  list_size = 2'b00;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_set = 1'b0;
    logic        sts_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic [1:0]  irq_thr = 2'b00;
    logic [31:0] entry_addr;
    logic        list_wrap;
    logic        irq_status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfl_index_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .uframe_end (uframe_end),
        .list_size  (list_size),
        .bus_wr     (bus_wr),
        .bus_sel    (bus_sel),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_set    (evt_set),
        .sts_clr    (sts_clr),
        .irq_en     (irq_en),
        .irq_thr    (irq_thr),
        .entry_addr (entry_addr),
        .list_wrap  (list_wrap),
        .irq_status (irq_status),
        .irq        (irq)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_be = be; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        bus_sel = sel;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] base;
        int m;
        int nbit;
        int imask;

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;

        // R1 reset state
        rd(1'b0, v); chk("R1 fidx reset", v, 32'h0);
        rd(1'b1, v); chk("R1 base reset", v, 32'h0);
        chk("R1 entry reset", entry_addr, 32'h0);
        chk("R1 irq/status/wrap reset", {29'h0, irq, irq_status, list_wrap}, 32'h0);

        // R1 upper bits zero on a full-ones write
        wr(1'b0, 4'hF, 32'hFFFF_FFFF);
        rd(1'b0, v); chk("R1 fidx width", v, 32'h0000_3FFF);

        // R3 halted write accepted, running write ignored
        wr(1'b0, 4'hF, 32'h0000_1234);
        rd(1'b0, v); chk("R3 halted load", v, 32'h0000_1234);
        run_en = 1'b1;
        wr(1'b0, 4'hF, 32'h0000_0777);
        rd(1'b0, v); chk("R3 running write ignored", v, 32'h0000_1234);
        run_en = 1'b0;

        // R2 no advance while halted
        uframe_end = 1'b1; cyc(); cyc(); uframe_end = 1'b0;
        rd(1'b0, v); chk("R2 hold when halted", v, 32'h0000_1234);

        // R5 base keeps bits 31:12
        wr(1'b1, 4'hF, 32'h1234_5FFF);
        rd(1'b1, v); chk("R5 base readback", v, 32'h1234_5000);

        // R4 partial writes ignored on both registers
        wr(1'b0, 4'h7, 32'h0000_0055);
        rd(1'b0, v); chk("R4 partial fidx write", v, 32'h0000_1234);
        wr(1'b1, 4'hE, 32'hFFFF_F000);
        rd(1'b1, v); chk("R4 partial base write", v, 32'h1234_5000);

        // R2 R6 R7 full sweep of the counter for every list-size code
        for (int sz = 0; sz < 4; sz++) begin
            base = 32'hA000_0000 + (sz << 12) + (sz << 24);
            list_size = sz[1:0];
            wr(1'b1, 4'hF, base);
            wr(1'b0, 4'hF, 32'h0);
            nbit  = (sz == 1) ? 11 : (sz == 2) ? 10 : 12;
            imask = (sz == 1) ? 32'h1FF : (sz == 2) ? 32'hFF : 32'h3FF;
            chk("R6 entry at zero", entry_addr, base);
            m = 0;
            run_en = 1'b1; uframe_end = 1'b1;
            for (int k = 0; k < 16384; k++) begin
                int nm;
                logic exp_wrap;
                cyc();
                nm = (m + 1) & 32'h3FFF;
                exp_wrap = (((m >> nbit) & 1) == 1) && (((nm >> nbit) & 1) == 0);
                m = nm;
                chk("R6 entry address", entry_addr,
                    base | (((m >> 3) & imask) << 2));
                chk("R7 list wrap pulse", {31'h0, list_wrap}, {31'h0, exp_wrap});
            end
            run_en = 1'b0; uframe_end = 1'b0;
            rd(1'b0, v); chk("R2 wrap to zero after 2^14", v, 32'h0);
        end
        list_size = 2'b00;

        // R8 status set, clear, set priority
        evt_set = 1'b1; sts_clr = 1'b1; cyc(); evt_set = 1'b0; sts_clr = 1'b0;
        chk("R8 set wins", {31'h0, irq_status}, 32'h1);
        sts_clr = 1'b1; cyc(); sts_clr = 1'b0;
        chk("R8 clear", {31'h0, irq_status}, 32'h0);

        // R9 R10 threshold sweep
        for (int t = 0; t < 4; t++) begin
            bit fired;
            irq_thr = t[1:0];
            irq_en = 1'b1;
            wr(1'b0, 4'hF, 32'd5);
            m = 5;
            evt_set = 1'b1; cyc(); evt_set = 1'b0;
            chk("R8 status set", {31'h0, irq_status}, 32'h1);
            cyc(); cyc();
            chk("R9 no irq without boundary", {31'h0, irq}, 32'h0);
            fired = 1'b0;
            for (int k = 0; k < 10; k++) begin
                run_en = 1'b1; uframe_end = 1'b1;
                cyc();
                run_en = 1'b0; uframe_end = 1'b0;
                m = (m + 1) & 32'h3FFF;
                if (!fired && ((m & ((1 << t) - 1)) == 0)) fired = 1'b1;
                chk("R9 irq at threshold", {31'h0, irq}, {31'h0, fired});
            end
            sts_clr = 1'b1; cyc(); sts_clr = 1'b0;
            chk("R10 irq falls on acknowledge", {30'h0, irq, irq_status}, 32'h0);
        end

        // R10 enable drop, R9 re-arm waits for a boundary
        irq_thr = 2'b00;
        evt_set = 1'b1; cyc(); evt_set = 1'b0;
        cyc(); cyc();
        run_en = 1'b1; uframe_end = 1'b1; cyc(); run_en = 1'b0; uframe_end = 1'b0;
        chk("R9 irq with threshold 1", {31'h0, irq}, 32'h1);
        irq_en = 1'b0;
        #1;
        chk("R10 irq falls with enable", {31'h0, irq}, 32'h0);
        cyc();
        irq_en = 1'b1;
        cyc(); cyc();
        chk("R9 re-armed waits for boundary", {31'h0, irq}, 32'h0);
        run_en = 1'b1; uframe_end = 1'b1; cyc(); run_en = 1'b0; uframe_end = 1'b0;
        chk("R9 re-armed fires", {31'h0, irq}, 32'h1);
        sts_clr = 1'b1; cyc(); sts_clr = 1'b0;
        chk("R10 final acknowledge", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule